// File: doc/BRIEF.md
# RS485 Half-Duplex Bus Direction Controller

This block turns a half-duplex RS485 line around between receive and transmit on behalf of a byte-oriented serial transmitter. It has one direction output, `dir`. That output is wired both to the line driver's enable pin and to the transceiver's active-low receiver enable, so a single level picks the bus direction. When `dir` is high the node drives the line and its receiver is off. When `dir` is low the node listens and its driver is off.

A start request turns the bus to transmit. An optional settling gap, counted in bit periods, may follow. The block then pulls bytes from an external first-word-fall-through queue and hands them to the transmitter each time the transmitter's holding register is free. When the queue runs dry it stops feeding but keeps the line driven. It releases the bus only when the transmitter signals that the final stop bit has left the shift register. It does not release the bus when the queue empties or when the last byte is loaded.

Top module: `rs485_turnaround`

## Requirements
- R1: After reset `dir` is 0, `rx_en` is 1, `tx_en` is 0, and neither `q_pop` nor `tx_load` is asserted.
- R2: With `gap_bits` = 0 and a non-empty queue, a `start_req` sampled on a clock edge gives `dir` = 1, `rx_en` = 0 and `tx_en` = 1 in the next cycle. While `dir` is 0, `tx_load` is never asserted.
- R3: With `gap_bits` = N > 0, no byte is loaded until N `bit_tick` pulses have been sampled after the start. The first load may occur in the cycle right after the edge that samples the Nth pulse.
- R4: While feeding, a cycle with `tx_empty` = 1 and `q_empty` = 0 asserts `q_pop` and `tx_load` together, with `tx_data` equal to `q_data`. Bytes therefore leave in queue order.
- R5: `tx_load` is never asserted in two consecutive cycles, even if `tx_empty` stays high.
- R6: Once the queue has emptied, `dir` stays 1 and no further byte is loaded until `tx_done` is seen.
- R7: A `tx_done` pulse received after the queue has emptied gives `dir` = 0, `rx_en` = 1 and `tx_en` = 0 in the next cycle.
- R8: A `start_req` that arrives while the bus is already turned to transmit is ignored. In particular, it does not restart the settling gap.
- R9: A `start_req` with an empty queue leaves `dir` at 0.
- R10: A `tx_done` pulse during the settling gap is ignored, and `dir` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to turn the bus around and send the queued bytes |
| gap_bits | input | GAP_W | Settling gap in bit periods, sampled at start; 0 skips the gap |
| bit_tick | input | 1 | One-cycle strobe once per bit period |
| q_data | input | DATA_W | Head byte of the transmit queue |
| q_empty | input | 1 | Transmit queue holds no byte |
| q_pop | output | 1 | Removes the head byte from the queue |
| tx_data | output | DATA_W | Byte handed to the transmitter |
| tx_load | output | 1 | Writes `tx_data` into the transmitter holding register |
| tx_empty | input | 1 | Transmitter holding register can accept a byte |
| tx_done | input | 1 | Pulse: last stop bit has left the shift register, nothing pending |
| tx_en | output | 1 | Transmitter and its data-empty servicing enabled |
| rx_en | output | 1 | Local receiver and its receive event enabled |
| dir | output | 1 | Bus direction: 1 drive the line, 0 listen |

## Verification
The hardest cases to reach from the ports are those that need stimulus at a precise moment inside the turnaround. One is a second start request, or a stray transmit-complete pulse, that lands while the settling gap is still counting. The other is a holding register that stays free for several cycles in a row. The bench drives `bit_tick` by hand, one pulse at a time, and injects a start and a `tx_done` between pulses. It then checks that the first load still appears right after the third pulse. For the back-to-back case, the transmitter model is switched off and `tx_empty` is held high, which exposes the one-load-per-two-cycles spacing. A byte scoreboard checks the order of all loaded bytes across every phase.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    typedef enum logic [1:0] {
        S_RX    = 2'd0,
        S_GAP   = 2'd1,
        S_FEED  = 2'd2,
        S_DRAIN = 2'd3
    } dir_state_e;

    typedef struct packed {
        logic dir;
        logic rx_en;
        logic tx_en;
        logic feed_en;
        logic gap_run;
    } dir_ctl_t;

    function automatic dir_ctl_t decode_state(dir_state_e st);
        dir_ctl_t c;
        c.dir     = (st != S_RX);
        c.rx_en   = (st == S_RX);
        c.tx_en   = (st != S_RX);
        c.feed_en = (st == S_FEED);
        c.gap_run = (st == S_GAP);
        return c;
    endfunction

endpackage

// File: rtl/rs485_gap_timer.sv
module rs485_gap_timer #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic [GAP_W-1:0] len_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic             expire_o
);
    localparam logic [GAP_W-1:0] LAST = GAP_W'(1);

    logic [GAP_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (arm_i) begin
            rem_q <= len_i;
        end else if (run_i && tick_i && rem_q != '0) begin
            rem_q <= rem_q - LAST;
        end
    end

    assign expire_o = run_i && tick_i && (rem_q == LAST);

endmodule

// File: rtl/rs485_byte_feeder.sv
module rs485_byte_feeder #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              tx_empty_i,
    input  logic              q_empty_i,
    input  logic [DATA_W-1:0] q_data_i,
    output logic              q_pop_o,
    output logic              tx_load_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              drained_o
);
    logic load_q;
    logic free;

    // A register that has just been written is given one cycle for its empty flag to fall.
    assign free      = en_i && tx_empty_i && !load_q;
    assign tx_load_o = free && !q_empty_i;
    assign q_pop_o   = tx_load_o;
    assign tx_data_o = q_data_i;
    assign drained_o = free && q_empty_i;

    always_ff @(posedge clk) begin
        if (rst) load_q <= 1'b0;
        else     load_q <= tx_load_o;
    end

    assert_load_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        tx_load_o |=> !tx_load_o);

endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
    import rs485_dir_pkg::*;
#(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic             q_empty_i,
    input  logic             tick_i,
    input  logic             expire_i,
    input  logic             drained_i,
    input  logic             tx_done_i,
    output logic             arm_o,
    output dir_ctl_t         ctl_o
);
    dir_state_e st_q, st_d;

    always_comb begin
        st_d  = st_q;
        arm_o = 1'b0;
        unique case (st_q)
            S_RX: begin
                if (start_i && !q_empty_i) begin
                    arm_o = 1'b1;
                    st_d  = (gap_i == '0) ? S_FEED : S_GAP;
                end
            end
            S_GAP: begin
                if (expire_i) st_d = S_FEED;
            end
            S_FEED: begin
                if (drained_i) st_d = tx_done_i ? S_RX : S_DRAIN;
            end
            S_DRAIN: begin
                if (tx_done_i) st_d = S_RX;
            end
            default: st_d = S_RX;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= S_RX;
        else     st_q <= st_d;
    end

    assign ctl_o = decode_state(st_q);

    assert_empty_start_stays_rx_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_RX && start_i && q_empty_i) |=> (st_q == S_RX));

    assert_start_ignored_in_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_DRAIN && start_i && !tx_done_i) |=> (st_q == S_DRAIN));

    assert_gap_waits_for_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_GAP && !tick_i) |=> (st_q == S_GAP));

    assert_gap_ignores_done_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_GAP && tx_done_i && !tick_i) |=> (st_q != S_RX));

endmodule

// File: rtl/rs485_turnaround.sv
module rs485_turnaround
    import rs485_dir_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [GAP_W-1:0]  gap_bits,
    input  logic              bit_tick,
    input  logic [DATA_W-1:0] q_data,
    input  logic              q_empty,
    output logic              q_pop,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_load,
    input  logic              tx_empty,
    input  logic              tx_done,
    output logic              tx_en,
    output logic              rx_en,
    output logic              dir
);
    dir_ctl_t ctl;
    logic     arm;
    logic     expire;
    logic     drained;

    rs485_dir_fsm #(.GAP_W(GAP_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_req),
        .gap_i     (gap_bits),
        .q_empty_i (q_empty),
        .tick_i    (bit_tick),
        .expire_i  (expire),
        .drained_i (drained),
        .tx_done_i (tx_done),
        .arm_o     (arm),
        .ctl_o     (ctl)
    );

    rs485_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .arm_i    (arm),
        .len_i    (gap_bits),
        .run_i    (ctl.gap_run),
        .tick_i   (bit_tick),
        .expire_o (expire)
    );

    rs485_byte_feeder #(.DATA_W(DATA_W)) u_feed (
        .clk        (clk),
        .rst        (rst),
        .en_i       (ctl.feed_en),
        .tx_empty_i (tx_empty),
        .q_empty_i  (q_empty),
        .q_data_i   (q_data),
        .q_pop_o    (q_pop),
        .tx_load_o  (tx_load),
        .tx_data_o  (tx_data),
        .drained_o  (drained)
    );

    assign dir   = ctl.dir;
    assign rx_en = ctl.rx_en;
    assign tx_en = ctl.tx_en;

    assert_no_load_while_listening_R2: assert property (@(posedge clk) disable iff (rst)
        !dir |-> !tx_load);

    assert_release_only_on_done_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(dir) |-> $past(tx_done));

    assert_no_load_after_drain_R6: assert property (@(posedge clk) disable iff (rst)
        (dir && q_empty) |-> !tx_load);

endmodule

// File: tb/tb_rs485_turnaround.sv
module tb_rs485_turnaround;
    localparam int DW = 8;
    localparam int GW = 4;
    localparam int SH = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1, start_req = 1'b0, bit_tick = 1'b0, inj_done = 1'b0;
    logic          auto_tx = 1'b1, force_empty = 1'b0;
    logic [GW-1:0] gap_bits = '0;
    logic [DW-1:0] qmem [0:15];
    int            qhd = 0, qtl = 0;
    logic          hold_full = 1'b0, model_done = 1'b0;
    int            shift_cnt = 0;

    logic [DW-1:0] q_data, tx_data;
    logic          q_empty, q_pop, tx_load, tx_empty, tx_done, tx_en, rx_en, dir;

    assign q_empty  = (qhd == qtl);
    assign q_data   = qmem[qtl[3:0]];
    assign tx_empty = auto_tx ? !hold_full : force_empty;
    assign tx_done  = model_done | inj_done;

    rs485_turnaround #(.DATA_W(DW), .GAP_W(GW)) dut (
        .clk(clk), .rst(rst), .start_req(start_req), .gap_bits(gap_bits),
        .bit_tick(bit_tick), .q_data(q_data), .q_empty(q_empty), .q_pop(q_pop),
        .tx_data(tx_data), .tx_load(tx_load), .tx_empty(tx_empty), .tx_done(tx_done),
        .tx_en(tx_en), .rx_en(rx_en), .dir(dir)
    );

    int            n_cmp = 0, n_bad = 0, loads = 0;
    logic [DW-1:0] exp_q [$];
    logic          prev_ld = 1'b0;
    bit            finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic push_byte(input logic [DW-1:0] b);
        qmem[qhd[3:0]] = b;
        qhd++;
        exp_q.push_back(b);
    endtask

    task automatic pulse_start();
        step(); start_req = 1'b1;
        step(); start_req = 1'b0;
    endtask

    task automatic pulse_tick();
        step(); bit_tick = 1'b1;
        step(); bit_tick = 1'b0;
    endtask

    task automatic pulse_done();
        step(); inj_done = 1'b1;
        step(); inj_done = 1'b0;
    endtask

    // Waits for the transmit-complete pulse, then checks the release (R6, R7).
    task automatic wait_release();
        int guard = 0;
        @(negedge clk);
        while (!tx_done && guard < 500) begin @(negedge clk); guard++; end
        chk(dir == 1'b1, "R6 dir held until tx_done", dir, 1);
        chk(exp_q.size() == 0, "R4 all bytes loaded", exp_q.size(), 0);
        @(negedge clk);
        chk(dir == 1'b0, "R7 dir after tx_done", dir, 0);
        chk(rx_en == 1'b1, "R7 rx_en after tx_done", rx_en, 1);
        chk(tx_en == 1'b0, "R7 tx_en after tx_done", tx_en, 0);
    endtask

    // Transmitter and queue model: observe mid-cycle, apply just after the edge.
    initial begin
        forever begin
            logic s_pop, s_ld;
            @(negedge clk);
            s_pop = q_pop; s_ld = tx_load;
            step();
            if (rst) begin
                hold_full = 1'b0; shift_cnt = 0; model_done = 1'b0;
            end else begin
                if (s_pop) qtl++;
                model_done = 1'b0;
                if (auto_tx) begin
                    if (shift_cnt > 0) begin
                        shift_cnt--;
                        if (shift_cnt == 0 && !hold_full && !s_ld) model_done = 1'b1;
                    end
                    if (s_ld) hold_full = 1'b1;
                    if (shift_cnt == 0 && hold_full) begin
                        hold_full = 1'b0;
                        shift_cnt = SH;
                    end
                end
            end
        end
    end

    // Scoreboard monitor: each loaded byte against the expected order.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && tx_load) begin
                loads++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected load", tx_data, -1);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(tx_data == e, "R4 byte order", tx_data, e);
                end
                chk(q_pop == 1'b1, "R4 pop with load", q_pop, 1);
                chk(!prev_ld, "R5 back-to-back load", prev_ld, 0);
            end
            prev_ld = rst ? 1'b0 : tx_load;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(1'b0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int l0;
        repeat (3) step();
        rst = 1'b0;
        @(negedge clk);
        chk(dir == 1'b0, "R1 dir", dir, 0);
        chk(rx_en == 1'b1, "R1 rx_en", rx_en, 1);
        chk(tx_en == 1'b0, "R1 tx_en", tx_en, 0);
        chk(!tx_load && !q_pop, "R1 no load/pop", tx_load, 0);

        // R9: start with nothing queued
        pulse_start();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(dir == 1'b0, "R9 empty start", dir, 0);
        end

        // R2, R4, R6, R7: gap zero, five bytes through the transmitter model
        for (int i = 0; i < 5; i++) push_byte(8'hA0 + 8'(i * 7));
        pulse_start();
        @(negedge clk);
        chk(dir == 1'b1, "R2 dir", dir, 1);
        chk(rx_en == 1'b0, "R2 rx_en", rx_en, 0);
        chk(tx_en == 1'b1, "R2 tx_en", tx_en, 1);
        wait_release();

        // R5, R6, R7: holding register reported free every cycle
        auto_tx = 1'b0; force_empty = 1'b1;
        push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
        l0 = loads;
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(tx_load == ((i % 2) == 0), "R5 load spacing", tx_load, (i % 2) == 0);
        end
        chk(loads - l0 == 3, "R5 load count", loads - l0, 3);
        repeat (5) @(negedge clk);
        chk(dir == 1'b1, "R6 hold after drain", dir, 1);
        chk(tx_load == 1'b0, "R6 no load after drain", tx_load, 0);
        pulse_done();
        @(negedge clk);
        chk(dir == 1'b0, "R7 release on injected done", dir, 0);
        auto_tx = 1'b1; force_empty = 1'b0;

        // R3, R8, R10: gap of three bit periods
        gap_bits = 4'd3;
        push_byte(8'h5C); push_byte(8'hC5);
        l0 = loads;
        pulse_start();
        @(negedge clk);
        chk(dir == 1'b1 && tx_load == 1'b0, "R3 gap entered, no load", tx_load, 0);
        pulse_tick();
        @(negedge clk);
        chk(loads == l0, "R3 no load after tick 1", loads - l0, 0);
        pulse_start();
        pulse_tick();
        @(negedge clk);
        chk(loads == l0, "R8 no load after tick 2", loads - l0, 0);
        pulse_done();
        @(negedge clk);
        chk(dir == 1'b1, "R10 done ignored in gap", dir, 0 + 1);
        pulse_tick();
        @(negedge clk);
        chk(tx_load == 1'b1, "R3/R8 first load after tick 3", tx_load, 1);
        wait_release();
        repeat (4) @(negedge clk);
        chk(dir == 1'b0, "R8 no restart after release", dir, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule